// File: doc/BRIEF.md
# Three-Level Masked Interrupt Collector

This block gathers interrupt events from three source groups: normal, external and error. Each group has a 32-bit pending register. A source raises an event by presenting an identifier. The upper byte of the identifier chooses the group and the lower byte chooses the bit to set. External sources can also withdraw their own event with a cancel request.

Nine mask registers link the pending bits to three level request lines. There is one mask for each pair of group and level. A level line is high when any group has a pending bit that is also enabled in that group's mask for that level.

The host CPU uses a plain register port. Reads are combinational. A write takes effect at the next clock edge. Normal and error pending bits are cleared by writing ones. The CPU cannot clear external pending bits. A read of the normal pending register also reports, in its top two bits, whether any external or any error bit is pending.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset every pending register and every mask register reads zero, and the three level outputs are low.
- R2: A raise carries a 16-bit identifier. Bits 15:8 select the group: 0 is normal, 1 is external, 2 is error. Bits 7:0 give the bit index to set. A group code above 2 or an index of 32 or more changes nothing.
- R3: Each level output is registered. It goes high one clock after some group has a pending bit that is also set in that group's mask for that level, and it goes low one clock after no such bit remains.
- R4: The three outputs are `irq_hi`, `irq_mid` and `irq_lo`. They are driven by mask addresses 4–6, 8–10 and 12–14 respectively. Within each set of three addresses the order is normal, external, error.
- R5: Address 0 returns normal pending bits 29:0 unchanged. Bit 30 reads 1 when any external bit is pending. Bit 31 reads 1 when any error bit is pending. Stored normal bits 31:30 are not visible in this read.
- R6: A write to address 0 (normal) or address 2 (error) clears each pending bit where the write data is 1. Bits written with 0 keep their value.
- R7: A write to address 1 (external) has no effect. A cancel with index i clears external bit i.
- R8: A mask address reads back the last value written to it, and the new mask value affects its level output at the next clock edge.
- R9: When a raise and a clear (a CPU write or a cancel) hit the same pending bit in the same cycle, the bit ends up set.
- R10: Address 1 returns the external pending bits unchanged, and address 2 returns the error pending bits unchanged. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_valid | input | 1 | Raise request strobe |
| raise_id | input | 16 | Group code in bits 15:8, bit index in bits 7:0 |
| cancel_valid | input | 1 | External cancel strobe |
| cancel_idx | input | 8 | Index of the external bit to clear |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_hi | output | 1 | High-priority level request |
| irq_mid | output | 1 | Middle-priority level request |
| irq_lo | output | 1 | Low-priority level request |

## Verification
Two functions can act on the same pending bit in one cycle: a source raise, and a clear from either a CPU write-one or an external cancel. The bench provokes this in three ways. It drives a raise of a normal bit together with a write-one to that bit, while the same write also clears a second bit that was set earlier. It pairs an external raise with a cancel of the same index. It pairs an error raise with a write-one to that same bit. In each case the pending register is then read back. It must show the raised bit still set, while any other bit named in the same write is cleared.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        GRP_NORM = 2'd0,
        GRP_EXT  = 2'd1,
        GRP_ERR  = 2'd2
    } grp_e;

    // reg_addr[3:2]: 0 selects pending registers, 1..3 select mask banks hi/mid/lo
    localparam logic [1:0] BANK_STATUS = 2'd0;

    localparam int NUM_GRP = 3;
    localparam int NUM_LVL = 3;

endpackage

// File: rtl/irqc_status.sv
module irqc_status #(
    parameter int SRC_W   = 32,
    parameter int IDX_W   = 8,
    parameter bit CPU_CLR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_wr,
    input  logic [SRC_W-1:0] clr_data,
    input  logic             cancel_en,
    input  logic [IDX_W-1:0] cancel_idx,
    output logic [SRC_W-1:0] stat_o
);

    logic [SRC_W-1:0] stat_d, stat_q;
    logic [SRC_W-1:0] set_vec, cancel_vec, clr_vec;

    always_comb begin
        for (int i = 0; i < SRC_W; i++) begin
            set_vec[i]    = set_en    && (set_idx    == IDX_W'(i));
            cancel_vec[i] = cancel_en && (cancel_idx == IDX_W'(i));
        end
    end

    generate
        if (CPU_CLR) begin : g_cpu_clear
            assign clr_vec = (clr_wr ? clr_data : '0) | cancel_vec;
        end else begin : g_src_clear
            logic unused_wr;
            assign unused_wr = clr_wr ^ (^clr_data);
            assign clr_vec   = cancel_vec;
        end
    endgenerate

    // raise applied after clear so a same-cycle event survives
    always_comb begin
        stat_d = (stat_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/irqc_level_eval.sv
module irqc_level_eval #(
    parameter int SRC_W = 32,
    parameter int N_GRP = 3
) (
    input  logic [N_GRP-1:0][SRC_W-1:0] stat_i,
    input  logic [N_GRP-1:0][SRC_W-1:0] mask_i,
    output logic                        hit_o
);

    logic [N_GRP-1:0] grp_hit;

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            assign grp_hit[g] = |(stat_i[g] & mask_i[g]);
        end
    endgenerate

    assign hit_o = |grp_hit;

endmodule

// File: rtl/irqc_readmux.sv
module irqc_readmux #(
    parameter int SRC_W  = 32,
    parameter int N_GRP  = 3,
    parameter int N_LVL  = 3,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]                      addr,
    input  logic [N_GRP-1:0][SRC_W-1:0]            stat_i,
    input  logic [N_LVL-1:0][N_GRP-1:0][SRC_W-1:0] mask_i,
    output logic [SRC_W-1:0]                       rdata
);
    import irqc_pkg::*;

    logic [1:0] bank;
    logic [1:0] slot;
    logic [SRC_W-1:0] norm_view;

    assign bank = addr[3:2];
    assign slot = addr[1:0];

    always_comb begin
        norm_view            = stat_i[GRP_NORM];
        norm_view[SRC_W-2]   = |stat_i[GRP_EXT];
        norm_view[SRC_W-1]   = |stat_i[GRP_ERR];
    end

    always_comb begin
        rdata = '0;
        if (bank == BANK_STATUS) begin
            case (slot)
                2'd0:    rdata = norm_view;
                2'd1:    rdata = stat_i[GRP_EXT];
                2'd2:    rdata = stat_i[GRP_ERR];
                default: rdata = '0;
            endcase
        end else if (int'(slot) < N_GRP) begin
            rdata = mask_i[int'(bank) - 1][slot];
        end
    end

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
    parameter int SRC_W  = 32,
    parameter int ID_W   = 16,
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_valid,
    input  logic [ID_W-1:0]   raise_id,
    input  logic              cancel_valid,
    input  logic [IDX_W-1:0]  cancel_idx,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [SRC_W-1:0]  reg_wdata,
    output logic [SRC_W-1:0]  reg_rdata,
    output logic              irq_hi,
    output logic              irq_mid,
    output logic              irq_lo
);
    import irqc_pkg::*;

    localparam int N_GRP = NUM_GRP;
    localparam int N_LVL = NUM_LVL;
    localparam int GRP_W = ID_W - IDX_W;

    typedef struct packed {
        logic [N_LVL-1:0][N_GRP-1:0][SRC_W-1:0] mask;
        logic [N_LVL-1:0]                       lvl;
    } state_t;

    state_t state_d, state_q;

    logic [GRP_W-1:0] raise_grp;
    logic [IDX_W-1:0] raise_idx;
    logic [N_GRP-1:0][SRC_W-1:0] stat_q;
    logic [N_LVL-1:0][N_GRP-1:0][SRC_W-1:0] mask_q;
    logic [N_LVL-1:0] lvl_hit;

    assign raise_grp = raise_id[ID_W-1:IDX_W];
    assign raise_idx = raise_id[IDX_W-1:0];
    assign mask_q    = state_q.mask;

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_stat
            irqc_status #(
                .SRC_W  (SRC_W),
                .IDX_W  (IDX_W),
                .CPU_CLR(g != int'(GRP_EXT))
            ) u_stat (
                .clk       (clk),
                .rst_n     (rst_n),
                .set_en    (raise_valid && (raise_grp == GRP_W'(g))),
                .set_idx   (raise_idx),
                .clr_wr    (reg_wr && (reg_addr == ADDR_W'(g))),
                .clr_data  (reg_wdata),
                .cancel_en (cancel_valid && (g == int'(GRP_EXT))),
                .cancel_idx(cancel_idx),
                .stat_o    (stat_q[g])
            );
        end

        for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
            irqc_level_eval #(
                .SRC_W(SRC_W),
                .N_GRP(N_GRP)
            ) u_eval (
                .stat_i(stat_q),
                .mask_i(state_q.mask[l]),
                .hit_o (lvl_hit[l])
            );
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        for (int l = 0; l < N_LVL; l++) begin
            for (int g = 0; g < N_GRP; g++) begin
                if (reg_wr && reg_addr[3:2] == 2'(l + 1) && reg_addr[1:0] == 2'(g)) begin
                    state_d.mask[l][g] = reg_wdata;
                end
            end
        end
        state_d.lvl = lvl_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    irqc_readmux #(
        .SRC_W (SRC_W),
        .N_GRP (N_GRP),
        .N_LVL (N_LVL),
        .ADDR_W(ADDR_W)
    ) u_rd (
        .addr  (reg_addr),
        .stat_i(stat_q),
        .mask_i(mask_q),
        .rdata (reg_rdata)
    );

    assign irq_hi  = state_q.lvl[0];
    assign irq_mid = state_q.lvl[1];
    assign irq_lo  = state_q.lvl[2];

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int SRC_W  = 32,
    parameter int ID_W   = 16,
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          raise_valid,
    input logic [ID_W-1:0]               raise_id,
    input logic                          cancel_valid,
    input logic                          reg_wr,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic [SRC_W-1:0]              reg_wdata,
    input logic [2:0][SRC_W-1:0]         stat_q,
    input logic [2:0][2:0][SRC_W-1:0]    mask_q,
    input logic                          irq_hi,
    input logic                          irq_mid,
    input logic                          irq_lo
);

    logic [2:0] hit_now;
    always_comb begin
        for (int l = 0; l < 3; l++) begin
            hit_now[l] = |(stat_q[0] & mask_q[l][0]) |
                         |(stat_q[1] & mask_q[l][1]) |
                         |(stat_q[2] & mask_q[l][2]);
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> ({irq_hi, irq_mid, irq_lo} == 3'b000));

    p_raise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_valid && raise_id[ID_W-1:IDX_W] == '0 && raise_id[IDX_W-1:0] < SRC_W)
        |=> stat_q[0][$past(raise_id[IDX_W-1:0])]);

    p_bad_group_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_valid && raise_id[ID_W-1:IDX_W] > 2 && !reg_wr && !cancel_valid)
        |=> $stable(stat_q));

    p_level_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({irq_lo, irq_mid, irq_hi} == $past(hit_now)));

    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'd0 && !raise_valid)
        |=> ((stat_q[0] & $past(reg_wdata)) == '0));

    p_ext_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'd1 && !raise_valid && !cancel_valid)
        |=> $stable(stat_q[1]));

    p_raise_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_valid && raise_id[ID_W-1:IDX_W] == 2 && raise_id[IDX_W-1:0] < SRC_W && reg_wr && reg_addr == 4'd2)
        |=> stat_q[2][$past(raise_id[IDX_W-1:0])]);

endmodule

bind irq_mask_ctrl irqc_checker #(
    .SRC_W (SRC_W),
    .ID_W  (ID_W),
    .IDX_W (IDX_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .raise_valid (raise_valid),
    .raise_id    (raise_id),
    .cancel_valid(cancel_valid),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .stat_q      (stat_q),
    .mask_q      (mask_q),
    .irq_hi      (irq_hi),
    .irq_mid     (irq_mid),
    .irq_lo      (irq_lo)
);

// File: tb/irq_mask_ctrl_test.sv
`timescale 1ns/1ps
module irq_mask_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raise_valid = 1'b0;
    logic [15:0] raise_id = '0;
    logic        cancel_valid = 1'b0;
    logic [7:0]  cancel_idx = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_hi, irq_mid, irq_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    irq_mask_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .raise_valid(raise_valid), .raise_id(raise_id),
        .cancel_valid(cancel_valid), .cancel_idx(cancel_idx),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_hi(irq_hi), .irq_mid(irq_mid), .irq_lo(irq_lo)
    );

    // monitor: compares queued expectations away from the rising edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_irq ? {29'd0, irq_hi, irq_mid, irq_lo} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: %s actual=%h expected=%h",
                         it.tag, it.is_irq ? "irq" : "rdata", act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic raise(input logic [15:0] id);
        raise_valid = 1'b1; raise_id = id;
        step();
        raise_valid = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic cancel(input logic [7:0] idx);
        cancel_valid = 1'b1; cancel_idx = idx;
        step();
        cancel_valid = 1'b0;
    endtask

    task automatic exp_rd(input logic [3:0] a, input logic [31:0] v, input string tag);
        item_t it;
        reg_addr = a;
        it.is_irq = 1'b0; it.exp = v; it.tag = tag;
        sb_q.push_back(it);
        step();
    endtask

    task automatic exp_irq(input logic [2:0] v, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {29'd0, v}; it.tag = tag;
        sb_q.push_back(it);
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R1: everything clear after reset
        for (int a = 0; a < 16; a++) exp_rd(4'(a), 32'h0, "R1");
        exp_irq(3'b000, "R1");

        // R2: normal raise of bit 3, no mask yet
        raise(16'h0003);
        exp_rd(4'd0, 32'h0000_0008, "R2");
        exp_irq(3'b000, "R3");

        // R8/R3/R4: hi mask on normal, registered update
        wr(4'd4, 32'h0000_0008);
        exp_irq(3'b000, "R3");
        exp_irq(3'b100, "R4");
        exp_rd(4'd4, 32'h0000_0008, "R8");

        // R10/R5: external bit 5
        raise(16'h0105);
        exp_rd(4'd1, 32'h0000_0020, "R10");
        exp_rd(4'd0, 32'h4000_0008, "R5");
        wr(4'd13, 32'h0000_0020);
        exp_irq(3'b100, "R3");
        exp_irq(3'b101, "R4");

        // R7: CPU write to external ignored, cancel clears
        wr(4'd1, 32'hFFFF_FFFF);
        exp_rd(4'd1, 32'h0000_0020, "R7");
        exp_irq(3'b101, "R7");
        cancel(8'd5);
        exp_rd(4'd1, 32'h0, "R7");
        exp_irq(3'b100, "R7");

        // error bit 0 and mid mask
        raise(16'h0200);
        exp_rd(4'd0, 32'h8000_0008, "R5");
        exp_rd(4'd2, 32'h0000_0001, "R10");
        wr(4'd10, 32'h0000_0001);
        exp_rd(4'd10, 32'h0000_0001, "R8");
        exp_irq(3'b110, "R4");

        // R6: write-one-to-clear
        wr(4'd0, 32'h0000_0008);
        exp_rd(4'd0, 32'h8000_0000, "R6");
        exp_irq(3'b010, "R6");
        wr(4'd2, 32'h0);
        exp_rd(4'd2, 32'h0000_0001, "R6");
        wr(4'd2, 32'h0000_0001);
        exp_rd(4'd2, 32'h0, "R6");
        exp_irq(3'b000, "R6");

        // R2: bad group and out-of-range index ignored
        raise(16'h0304);
        raise(16'h0028);
        exp_rd(4'd0, 32'h0, "R2");
        exp_rd(4'd1, 32'h0, "R2");
        exp_rd(4'd2, 32'h0, "R2");

        // R5: stored normal bit 30 hidden in the read
        raise(16'h001E);
        exp_rd(4'd0, 32'h0, "R5");
        wr(4'd0, 32'h4000_0000);

        // R9: raise beats same-cycle clear
        raise(16'h0001);
        raise_valid = 1'b1; raise_id = 16'h0007;
        reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h0000_0082;
        step();
        raise_valid = 1'b0; reg_wr = 1'b0;
        exp_rd(4'd0, 32'h0000_0080, "R9");

        raise_valid = 1'b1; raise_id = 16'h0102;
        cancel_valid = 1'b1; cancel_idx = 8'd2;
        step();
        raise_valid = 1'b0; cancel_valid = 1'b0;
        exp_rd(4'd1, 32'h0000_0004, "R9");

        raise_valid = 1'b1; raise_id = 16'h0203;
        reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h0000_0008;
        step();
        raise_valid = 1'b0; reg_wr = 1'b0;
        exp_rd(4'd2, 32'h0000_0008, "R9");

        step();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule